// File: doc/BRIEF.md
# Multi-mode timer timebase counter

This block is the counting core of a general-purpose timer. A prescaler divides the input clock by a programmable value plus one. A counter advances once per prescaler tick and runs in one of five modes. It can count up and wrap, count down and reload, or count up to the reload value and back down to 0. The up-and-down form has three variants. They differ only in the counting phase during which compare channels may raise their flags.

Each wrap or turnaround of the counter produces a one-cycle update event. The update event reloads the prescaler and the preloaded reload value. It also sets a sticky update flag, which drives an interrupt output when the interrupt enable is high. Software can force an update with a strobe. An update-source control stops that strobe from setting the flag.

Configuration is written through plain single-cycle strobes with a data word each. Level inputs hold the enable bit, the update-source select, the preload enable and the interrupt enable. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `tmb_timebase`

## Requirements
- R1: After reset the count, direction, update event, update flag and interrupt are all 0, and the mode is edge up (mode code 0).
- R2: In edge up mode (mode code 0) the count steps 0,1,...,A on each tick, where A is the active reload value. On the tick at A it returns to 0, and the update event is high for the one cycle that follows.
- R3: In edge down mode (mode code 1) the count steps down to 0 and then reloads A, with an update event on the reload. In this mode the direction output is 1.
- R4: In the three center modes (codes 2, 3 and 4) the count runs 0 up to A and then back down to 0. Both turnarounds raise an update event, so one full cycle is 2×A ticks. The direction output is 1 from the tick that leaves A until the tick that leaves 0.
- R5: The phase qualifier `cmp_phase_ok` depends on the mode. It is always 1 in codes 0, 1 and 4. In code 2 it follows the direction output. In code 3 it is the inverse of the direction output.
- R6: A tick occurs every P+1 clocks while running, so an edge-mode period is (A+1)×(P+1) clocks. A newly written prescaler value P takes effect only at the next update event or software update.
- R7: A mode write is ignored while `run_en` is high. A write of an undefined code (5 to 7) is also ignored.
- R8: A software update strobe clears the prescaler phase and loads the prescaler and reload values. It sets the count to 0, or to A in edge down mode, and sets the direction for the mode. The update event is high in the next cycle.
- R9: When `urs_cnt_only` is 1, a software update does not set the update flag. Counter overflow and underflow still set it.
- R10: The update flag stays set until `flag_clr`. A set in the same cycle wins over a clear. `upd_irq` is high exactly when the flag and `uie` are both 1.
- R11: With `arr_preload_en` at 1, a written reload value becomes active only at the next update. With it at 0, the value is active from the next cycle.
- R12: A count write loads the value when stopped and is ignored while running. With `run_en` low and no software update, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counter enable |
| psc_we | input | 1 | Prescaler write strobe |
| psc_wdata | input | PSC_W | Prescaler value (divide by value+1) |
| arr_we | input | 1 | Reload write strobe |
| arr_wdata | input | CNT_W | Reload value |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code 0..4 |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count value |
| ug_req | input | 1 | Software update strobe |
| urs_cnt_only | input | 1 | 1: only counter wraps set the flag |
| arr_preload_en | input | 1 | Reload preload enable |
| uie | input | 1 | Update interrupt enable |
| flag_clr | input | 1 | Clear the update flag |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | 1 while counting down |
| upd_evt | output | 1 | One-cycle update event |
| upd_flag | output | 1 | Sticky update flag |
| upd_irq | output | 1 | Update interrupt |
| cmp_phase_ok | output | 1 | Compare flags may be set in this phase |

## Verification
The assertions take every strobe to be a single-cycle pulse sampled at the rising edge. They also take the count to lie within the active reload value, or to have been written while stopped, before the wrap properties are judged. The stimulus drives all strobes for exactly one cycle, away from the clock edge. It writes counts and reload values only while the counter is stopped, and it never issues a reload write in the same cycle as an update.

// File: rtl/tmb_pkg.sv
`timescale 1ns/1ps
package tmb_pkg;
  typedef enum logic [2:0] {
    TMB_EDGE_UP    = 3'd0,
    TMB_EDGE_DN    = 3'd1,
    TMB_CTR_DNFLAG = 3'd2,
    TMB_CTR_UPFLAG = 3'd3,
    TMB_CTR_BOTH   = 3'd4
  } tmb_mode_e;

  localparam logic [2:0] TMB_MODE_MAX = 3'd4;

  function automatic logic tmb_is_center(tmb_mode_e m);
    return (m == TMB_CTR_DNFLAG) || (m == TMB_CTR_UPFLAG) || (m == TMB_CTR_BOTH);
  endfunction
endpackage

// File: rtl/tmb_prescaler.sv
`timescale 1ns/1ps
module tmb_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  output logic             tick
);
  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

  logic [PSC_W-1:0] psc_pre;
  logic [PSC_W-1:0] psc_act;
  logic [PSC_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_pre <= '0;
    else if (psc_we) psc_pre <= psc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      phase   <= '0;
    end else if (reload) begin
      psc_act <= psc_pre;
      phase   <= '0;
    end else if (run) begin
      phase <= (phase == psc_act) ? '0 : phase + ONE;
    end
  end

  assign tick = run && (phase == psc_act);

  assert_psc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= psc_act) else $error("prescaler phase beyond limit");

  assert_psc_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload) |=> $stable(phase)) else $error("prescaler moved while idle");
endmodule

// File: rtl/tmb_counter.sv
`timescale 1ns/1ps
module tmb_counter
  import tmb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             ug,
  input  logic             mode_we,
  input  logic [2:0]       mode_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             arpe,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             cnt_evt,
  output logic             cmp_ok
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tmb_mode_e        mode_q;
  logic             dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] arr_pre;
  logic [CNT_W-1:0] arr_act;
  logic             at_top;
  logic             at_zero;
  logic             mode_ok;

  assign at_top  = (cnt_q == arr_act);
  assign at_zero = (cnt_q == '0);
  assign mode_ok = (mode_wdata <= TMB_MODE_MAX) && !run;

  // wrap / turnaround detection
  always_comb begin
    cnt_evt = 1'b0;
    unique case (mode_q)
      TMB_EDGE_UP: cnt_evt = tick && at_top;
      TMB_EDGE_DN: cnt_evt = tick && at_zero;
      default:     cnt_evt = tick && (dir_q ? at_zero : at_top);
    endcase
  end

  // mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TMB_EDGE_UP;
    else if (mode_we && mode_ok) mode_q <= tmb_mode_e'(mode_wdata);
  end

  // reload registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_pre <= '0;
      arr_act <= '0;
    end else begin
      if (ug || cnt_evt) arr_act <= arr_pre;
      if (arr_we) begin
        arr_pre <= arr_wdata;
        if (!arpe) arr_act <= arr_wdata;
      end
    end
  end

  // count and direction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (ug) begin
      cnt_q <= (mode_q == TMB_EDGE_DN) ? arr_pre : '0;
      dir_q <= (mode_q == TMB_EDGE_DN);
    end else if (mode_we && mode_ok) begin
      dir_q <= (mode_wdata == 3'(TMB_EDGE_DN));
    end else if (cnt_we && !run) begin
      cnt_q <= cnt_wdata;
    end else if (tick) begin
      unique case (mode_q)
        TMB_EDGE_UP: cnt_q <= at_top ? '0 : cnt_q + ONE;
        TMB_EDGE_DN: cnt_q <= at_zero ? arr_pre : cnt_q - ONE;
        default: begin
          if (!dir_q) begin
            if (at_top) begin
              cnt_q <= (arr_act == '0) ? '0 : cnt_q - ONE;
              dir_q <= (arr_act != '0);
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end else begin
            if (at_zero) begin
              cnt_q <= (arr_pre == '0) ? '0 : ONE;
              dir_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  // phase qualifier for compare channels
  always_comb begin
    unique case (mode_q)
      TMB_CTR_DNFLAG: cmp_ok = dir_q;
      TMB_CTR_UPFLAG: cmp_ok = !dir_q;
      default:        cmp_ok = 1'b1;
    endcase
  end

  assign count    = cnt_q;
  assign dir_down = dir_q;

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_we) |=> $stable(mode_q)) else $error("mode changed while running");

  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TMB_EDGE_UP && tick && !ug && cnt_q == arr_act) |=> (cnt_q == '0))
    else $error("edge up did not wrap to zero");

  assert_dn_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TMB_EDGE_DN && tick && !ug && cnt_q == '0) |=> (cnt_q == $past(arr_pre)))
    else $error("edge down did not reload");

  assert_center_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmb_is_center(mode_q) && !dir_q && tick && !ug && !mode_we && cnt_q == arr_act && arr_act != '0)
    |=> dir_q) else $error("center mode missed the top turnaround");

  assert_stop_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug && !cnt_we) |=> $stable(cnt_q)) else $error("count moved while stopped");
endmodule

// File: rtl/tmb_update_ctrl.sv
`timescale 1ns/1ps
module tmb_update_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_evt,
  input  logic ug,
  input  logic urs_cnt_only,
  input  logic flag_clr,
  input  logic uie,
  output logic upd_evt,
  output logic upd_flag,
  output logic upd_irq
);
  logic set_flag;
  assign set_flag = cnt_evt || (ug && !urs_cnt_only);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_evt  <= 1'b0;
      upd_flag <= 1'b0;
    end else begin
      upd_evt <= cnt_evt || ug;
      if (set_flag) upd_flag <= 1'b1;
      else if (flag_clr) upd_flag <= 1'b0;
    end
  end

  assign upd_irq = upd_flag && uie;

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag && !flag_clr) |=> upd_flag) else $error("update flag dropped");

  assert_urs_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ug && urs_cnt_only && !cnt_evt && !upd_flag) |=> !upd_flag)
    else $error("software update set the flag in counter-only mode");

  assert_wrap_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt |=> (upd_flag && upd_evt)) else $error("wrap did not raise update");
endmodule

// File: rtl/tmb_timebase.sv
`timescale 1ns/1ps
module tmb_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             mode_we,
  input  logic [2:0]       mode_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ug_req,
  input  logic             urs_cnt_only,
  input  logic             arr_preload_en,
  input  logic             uie,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             upd_evt,
  output logic             upd_flag,
  output logic             upd_irq,
  output logic             cmp_phase_ok
);
  logic tick;
  logic cnt_evt;

  tmb_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .reload    (ug_req || cnt_evt),
    .psc_we    (psc_we),
    .psc_wdata (psc_wdata),
    .tick      (tick)
  );

  tmb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_en),
    .tick       (tick),
    .ug         (ug_req),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .arr_we     (arr_we),
    .arr_wdata  (arr_wdata),
    .arpe       (arr_preload_en),
    .count      (count),
    .dir_down   (dir_down),
    .cnt_evt    (cnt_evt),
    .cmp_ok     (cmp_phase_ok)
  );

  tmb_update_ctrl u_upd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_evt      (cnt_evt),
    .ug           (ug_req),
    .urs_cnt_only (urs_cnt_only),
    .flag_clr     (flag_clr),
    .uie          (uie),
    .upd_evt      (upd_evt),
    .upd_flag     (upd_flag),
    .upd_irq      (upd_irq)
  );

  assert_ug_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ug_req |=> upd_evt) else $error("software update gave no event");
endmodule

// File: tb/sim_tmb_timebase.sv
`timescale 1ns/1ps
module sim_tmb_timebase;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run_en = 1'b0;
  logic             psc_we = 1'b0;
  logic [PSC_W-1:0] psc_wdata = '0;
  logic             arr_we = 1'b0;
  logic [CNT_W-1:0] arr_wdata = '0;
  logic             mode_we = 1'b0;
  logic [2:0]       mode_wdata = '0;
  logic             cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic             ug_req = 1'b0;
  logic             urs_cnt_only = 1'b0;
  logic             arr_preload_en = 1'b0;
  logic             uie = 1'b0;
  logic             flag_clr = 1'b0;
  logic [CNT_W-1:0] count;
  logic             dir_down, upd_evt, upd_flag, upd_irq, cmp_phase_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmb_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_arr(input int v);
    arr_wdata = CNT_W'(v); arr_we = 1'b1; step(1); arr_we = 1'b0;
  endtask
  task automatic wr_psc(input int v);
    psc_wdata = PSC_W'(v); psc_we = 1'b1; step(1); psc_we = 1'b0;
  endtask
  task automatic wr_mode(input int v);
    mode_wdata = 3'(v); mode_we = 1'b1; step(1); mode_we = 1'b0;
  endtask
  task automatic wr_cnt(input int v);
    cnt_wdata = CNT_W'(v); cnt_we = 1'b1; step(1); cnt_we = 1'b0;
  endtask
  task automatic do_ug();
    ug_req = 1'b1; step(1); ug_req = 1'b0;
  endtask
  task automatic do_clr();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count", count, 0);
    chk("R1", "dir", dir_down, 0);
    chk("R1", "evt", upd_evt, 0);
    chk("R1", "flag", upd_flag, 0);
    chk("R1", "irq", upd_irq, 0);
    chk("R1", "cmp_ok edge up", cmp_phase_ok, 1);
  endtask

  task automatic t_edge_up();
    wr_psc(0); wr_arr(3); do_ug();
    chk("R8", "ug count", count, 0);
    chk("R8", "ug evt", upd_evt, 1);
    chk("R8", "ug flag", upd_flag, 1);
    do_clr();
    run_en = 1'b1;
    step(3);
    chk("R2", "count at top", count, 3);
    chk("R2", "no evt before wrap", upd_evt, 0);
    step(1);
    chk("R2", "wrap count", count, 0);
    chk("R2", "wrap evt", upd_evt, 1);
    chk("R2", "wrap flag", upd_flag, 1);
    chk("R5", "edge up cmp_ok", cmp_phase_ok, 1);
    run_en = 1'b0;
  endtask

  task automatic t_edge_down();
    wr_mode(1); do_ug();
    chk("R3", "ug loads reload", count, 3);
    chk("R3", "dir down", dir_down, 1);
    run_en = 1'b1;
    step(1); chk("R3", "step down", count, 2);
    step(2); chk("R3", "reach zero", count, 0);
    chk("R3", "no evt at zero", upd_evt, 0);
    step(1); chk("R3", "reload", count, 3);
    chk("R3", "reload evt", upd_evt, 1);
    run_en = 1'b0;
  endtask

  task automatic t_center();
    wr_mode(2); do_ug();
    chk("R4", "ug start", count, 0);
    chk("R5", "code2 up phase cmp_ok", cmp_phase_ok, 0);
    run_en = 1'b1;
    step(3); chk("R4", "top", count, 3);
    chk("R4", "still up", dir_down, 0);
    step(1); chk("R4", "turn down", count, 2);
    chk("R4", "dir after top", dir_down, 1);
    chk("R4", "evt at top", upd_evt, 1);
    chk("R5", "code2 down phase cmp_ok", cmp_phase_ok, 1);
    step(2); chk("R4", "bottom", count, 0);
    chk("R4", "no evt at bottom", upd_evt, 0);
    step(1); chk("R4", "turn up", count, 1);
    chk("R4", "dir after bottom", dir_down, 0);
    chk("R4", "evt at bottom", upd_evt, 1);
    run_en = 1'b0;
  endtask

  task automatic t_mode_guard();
    run_en = 1'b1;
    wr_mode(0);
    run_en = 1'b0;
    do_ug();
    chk("R7", "mode kept while running", cmp_phase_ok, 0);
    wr_mode(6); do_ug();
    chk("R7", "undefined code ignored", cmp_phase_ok, 0);
    wr_mode(3);
    chk("R5", "code3 up phase cmp_ok", cmp_phase_ok, 1);
    wr_mode(4);
    chk("R5", "code4 cmp_ok", cmp_phase_ok, 1);
  endtask

  task automatic t_prescale();
    wr_mode(0); wr_arr(3); wr_psc(2); do_ug(); do_clr();
    run_en = 1'b1;
    step(3); chk("R6", "first tick", count, 1);
    step(8); chk("R6", "count before period", count, 3);
    chk("R6", "no evt before period", upd_evt, 0);
    step(1); chk("R6", "period 12 wrap", count, 0);
    chk("R6", "period evt", upd_evt, 1);
    run_en = 1'b0;
    wr_psc(0);
    run_en = 1'b1;
    step(3); chk("R6", "new psc deferred", count, 1);
    run_en = 1'b0;
  endtask

  task automatic t_urs();
    urs_cnt_only = 1'b1;
    do_clr(); do_ug();
    chk("R9", "ug no flag", upd_flag, 0);
    chk("R9", "ug evt", upd_evt, 1);
    run_en = 1'b1;
    step(4);
    chk("R9", "overflow sets flag", upd_flag, 1);
    chk("R9", "overflow count", count, 0);
    run_en = 1'b0;
    urs_cnt_only = 1'b0;
  endtask

  task automatic t_preload();
    arr_preload_en = 1'b1;
    wr_arr(3); do_ug();
    wr_arr(5);
    run_en = 1'b1;
    step(3); chk("R11", "old reload top", count, 3);
    step(1); chk("R11", "wrap at old reload", count, 0);
    step(5); chk("R11", "new reload top", count, 5);
    step(1); chk("R11", "wrap at new reload", count, 0);
    run_en = 1'b0;
    arr_preload_en = 1'b0;
    wr_arr(1);
    run_en = 1'b1;
    step(1); chk("R11", "direct reload top", count, 1);
    step(1); chk("R11", "direct wrap", count, 0);
    chk("R11", "direct wrap evt", upd_evt, 1);
    run_en = 1'b0;
  endtask

  task automatic t_cnt_write();
    wr_arr(7); wr_cnt(2);
    chk("R12", "stopped write", count, 2);
    step(3);
    chk("R12", "stopped hold", count, 2);
    cnt_wdata = CNT_W'(6); cnt_we = 1'b1; run_en = 1'b1;
    step(1);
    cnt_we = 1'b0; run_en = 1'b0;
    chk("R12", "running write ignored", count, 3);
  endtask

  task automatic t_flag();
    do_clr();
    chk("R10", "cleared", upd_flag, 0);
    uie = 1'b0; do_ug();
    chk("R10", "flag set", upd_flag, 1);
    chk("R10", "irq masked", upd_irq, 0);
    uie = 1'b1; #1;
    chk("R10", "irq enabled", upd_irq, 1);
    step(3);
    chk("R10", "sticky", upd_flag, 1);
    do_clr();
    chk("R10", "clear flag", upd_flag, 0);
    chk("R10", "clear irq", upd_irq, 0);
    flag_clr = 1'b1; ug_req = 1'b1; step(1); flag_clr = 1'b0; ug_req = 1'b0;
    chk("R10", "set wins over clear", upd_flag, 1);
    uie = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_edge_up();
    t_edge_down();
    t_center();
    t_mode_guard();
    t_prescale();
    t_urs();
    t_preload();
    t_cnt_write();
    t_flag();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule